// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the serial audio edge of a multichannel converter. It runs on a fast system clock. It oversamples an incoming bit clock and frame clock and finds their edges. Three playback data lines are turned into six 24-bit channel words, a left and a right word per line. The words are presented in parallel with a one-cycle strobe once per frame. In the other direction, a stereo 24-bit record pair is shifted out on one serial line.

A 2-bit format field selects how playback words sit inside each half-frame. The options are left-aligned at the frame edge, delayed by one bit with the inverted frame-clock sense, or right-aligned with 20 or 24 significant bits. The record side is either left-aligned or one-bit-delayed. An auxiliary serial input can take the place of the record serializer on the output line. A 2-bit routing field can feed the output line back into the playback deserializer, replacing either lane 0 or the upper lanes. When the pin-control input is high, a routing pin pair is ORed with the register field.

Framing is tracked by a three-state machine. `ST_HUNT` waits for a frame-clock edge that opens a left half and then moves to `ST_LEFT`. In `ST_LEFT`, an edge into a right half latches the left words and moves to `ST_RIGHT`. In `ST_RIGHT`, an edge into a left half publishes the frame, fires the strobe and moves to `ST_LEFT`. Any other edge seen in `ST_RIGHT` drops back to `ST_HUNT`.

Top module: `sap_top`

## Requirements
- R1: After reset, `dac_words` and `dac_valid` are 0, and `adc_sd` is 0 until the first bit-clock falling edge.
- R2: With `dac_fmt`=00, a half-frame is left when the frame clock is high. The word's MSB is the first bit after the frame-clock edge, and 24 bits are taken. Later bits of the 32-bit half are ignored.
- R3: With `dac_fmt`=11, a half-frame is left when the frame clock is low. The MSB is the second bit after the edge, the 24 bits that follow are taken, and the first bit and the trailing bits are ignored.
- R4: With `dac_fmt`=10, the last 24 bit periods of each 32-bit half carry the word, MSB first. The first 8 bits are ignored.
- R5: With `dac_fmt`=01, the last 20 bit periods carry a 20-bit word. It appears in bits 23:4 of the channel word, with bits 3:0 zero, and the first 12 bits are ignored.
- R6: `dac_valid` pulses for one clock when a frame's right half ends at the next left-half edge, and only if that frame's left half was seen whole. All six words change only with that pulse. Channel c = 2*lane + side occupies bits [24c+23:24c], where side 0 is left.
- R7: `adc_sd` carries `adc_left`/`adc_right`, captured at the bit-clock falling edge that opens the left half, 24 bits MSB first. With `adc_i2s`=0 the word starts at bit 0 of the half and left is frame clock high. With `adc_i2s`=1 it starts at bit 1 and left is frame clock low. All other bit positions are 0.
- R8: Playback lines are sampled on bit-clock rising edges. `adc_sd` changes only after bit-clock falling edges.
- R9: With `aux_sel`=1, `adc_sd` repeats `aux_sd` as it was at each bit-clock falling edge.
- R10: With effective routing 01, lane 0 deserializes `adc_sd` instead of `dac_sd[0]`. This gives channels 0/1 equal to the record pair when both sides use the same framing, and `dac_sd[0]` has no effect.
- R11: With effective routing 10, lanes 1 and 2 deserialize `adc_sd`, and `dac_sd[2:1]` have no effect. Lane 0 is unchanged.
- R12: The effective routing is `loop_reg | loop_pin` when `par_ctl`=1 and `loop_reg` alone when `par_ctl`=0. Value 11 routes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| bclk | input | 1 | Serial bit clock |
| fclk | input | 1 | Frame (left/right) clock |
| dac_fmt | input | 2 | Playback framing: 00 left-aligned, 01 right-aligned 20, 10 right-aligned 24, 11 delayed |
| adc_i2s | input | 1 | Record framing: 0 left-aligned, 1 delayed |
| aux_sel | input | 1 | Put auxiliary input on the output line |
| loop_reg | input | 2 | Routing field from register |
| loop_pin | input | 2 | Routing field from pins |
| par_ctl | input | 1 | Pin control active: OR pins into routing |
| dac_sd | input | 3 | Playback serial lines |
| aux_sd | input | 1 | Auxiliary serial input |
| adc_left | input | 24 | Record left word |
| adc_right | input | 24 | Record right word |
| adc_sd | output | 1 | Record serial output |
| dac_words | output | 144 | Six channel words, channel c at [24c+23:24c] |
| dac_valid | output | 1 | One-cycle frame strobe |

## Verification
The bench sweeps every playback format. It fills the ignored bit slots with toggling junk, so a wrong window offset or a missing clear shows up as corrupted low or high bits. It uses all-ones and sign-edge words, so an off-by-one MSB position shows as a shifted word. Routing is tried through the register, through the pins with and without pin control, and with the reserved code. The playback lines carry junk while they are replaced, so a design that ignored the routing, or ORed the pins without pin control, would publish the junk words. Each frame's strobe count is checked, as is the record line, before and after each rising edge. This catches a serializer that loads the pair late, frames on the wrong clock sense, or changes on the rising edge.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;
    localparam logic [1:0] FMT_MSB   = 2'd0;
    localparam logic [1:0] FMT_LSB20 = 2'd1;
    localparam logic [1:0] FMT_LSB24 = 2'd2;
    localparam logic [1:0] FMT_DLY   = 2'd3;

    localparam logic [1:0] LOOP_LOW  = 2'd1;
    localparam logic [1:0] LOOP_HIGH = 2'd2;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sap_edge.sv
`timescale 1ns/1ps
module sap_edge #(
    parameter int SLOTS = 32,
    parameter int POSW  = $clog2(SLOTS) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            fclk,
    output logic            rise,
    output logic            fall,
    output logic            lr,
    output logic            half_start,
    output logic [POSW-1:0] pos,
    output logic [POSW-1:0] next_pos
);
    localparam logic [POSW-1:0] POS_MAX = '1;

    logic            bclk_q, bclk_q2, lr_last;
    logic [POSW-1:0] cnt, cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_q2 <= 1'b0;
            lr      <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            bclk_q2 <= bclk_q;
            lr      <= fclk;
        end
    end

    assign rise       = bclk_q & ~bclk_q2;
    assign fall       = ~bclk_q & bclk_q2;
    assign half_start = (lr != lr_last);
    assign cnt_inc    = (cnt == POS_MAX) ? cnt : cnt + 1'b1;
    assign pos        = half_start ? '0 : cnt_inc;
    assign next_pos   = half_start ? '0 : cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_last <= 1'b0;
            cnt     <= POS_MAX;
        end else if (rise) begin
            lr_last <= lr;
            cnt     <= pos;
        end
    end
endmodule

// File: rtl/sap_rx.sv
`timescale 1ns/1ps
module sap_rx
    import sap_pkg::*;
#(
    parameter int W       = 24,
    parameter int SLOTS   = 32,
    parameter int LANES   = 3,
    parameter int SHORT_W = 20,
    parameter int POSW    = $clog2(SLOTS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 half_start,
    input  logic [POSW-1:0]      pos,
    input  logic                 lr,
    input  logic [1:0]           fmt,
    input  logic [LANES-1:0]     lane_bit,
    output logic [LANES*2*W-1:0] words,
    output logic                 valid
);
    rx_state_e state, state_nx;
    logic      take, new_left, edge_now;

    assign edge_now = rise & half_start;
    assign new_left = (fmt == FMT_DLY) ? ~lr : lr;

    always_comb begin
        case (fmt)
            FMT_MSB:   take = pos < POSW'(W);
            FMT_LSB20: take = (pos >= POSW'(SLOTS - SHORT_W)) && (pos < POSW'(SLOTS));
            FMT_LSB24: take = (pos >= POSW'(SLOTS - W)) && (pos < POSW'(SLOTS));
            default:   take = (pos >= POSW'(1)) && (pos <= POSW'(W));
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (edge_now) begin
            unique case (state)
                ST_HUNT:  state_nx = new_left ? ST_LEFT : ST_HUNT;
                ST_LEFT:  state_nx = new_left ? ST_LEFT : ST_RIGHT;
                ST_RIGHT: state_nx = new_left ? ST_LEFT : ST_HUNT;
                default:  state_nx = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= edge_now && (state == ST_RIGHT) && new_left;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] sr, base, aligned, stage_l, word_l, word_r;
        assign base    = half_start ? '0 : sr;
        assign aligned = (fmt == FMT_LSB20) ? (sr << (W - SHORT_W)) : sr;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    sr <= '0;
            else if (rise) sr <= take ? {base[W-2:0], lane_bit[g]} : base;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_l <= '0;
                word_l  <= '0;
                word_r  <= '0;
            end else if (edge_now && state == ST_LEFT && !new_left) begin
                stage_l <= aligned;
            end else if (edge_now && state == ST_RIGHT && new_left) begin
                word_l  <= stage_l;
                word_r  <= aligned;
            end
        end

        assign words[(2*g)*W +: W]   = word_l;
        assign words[(2*g+1)*W +: W] = word_r;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6
    AST_VALID_FROM_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(state) == ST_RIGHT); // R6
    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> !valid); // R6
endmodule

// File: rtl/sap_tx.sv
`timescale 1ns/1ps
module sap_tx #(
    parameter int W     = 24,
    parameter int SLOTS = 32,
    parameter int POSW  = $clog2(SLOTS) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fall,
    input  logic            lr,
    input  logic [POSW-1:0] next_pos,
    input  logic            i2s,
    input  logic            aux_sel,
    input  logic            aux_bit,
    input  logic [W-1:0]    word_l,
    input  logic [W-1:0]    word_r,
    output logic            sd
);
    logic         nxt_left, load, in_win;
    logic [W-1:0] hold_l, hold_r, cur, shifted;
    int           shamt;

    assign nxt_left = i2s ? ~lr : lr;
    assign load     = fall && (next_pos == '0) && nxt_left;
    assign cur      = nxt_left ? (load ? word_l : hold_l) : hold_r;

    always_comb begin
        in_win = 1'b0;
        shamt  = 0;
        if (i2s) begin
            if (next_pos >= POSW'(1) && next_pos <= POSW'(W)) begin
                in_win = 1'b1;
                shamt  = W - int'(next_pos);
            end
        end else if (next_pos < POSW'(W)) begin
            in_win = 1'b1;
            shamt  = W - 1 - int'(next_pos);
        end
    end

    assign shifted = cur >> shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
            sd     <= 1'b0;
        end else if (fall) begin
            if (load) begin
                hold_l <= word_l;
                hold_r <= word_r;
            end
            sd <= aux_sel ? aux_bit : (in_win & shifted[0]);
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(sd)); // R8
endmodule

// File: rtl/sap_top.sv
`timescale 1ns/1ps
module sap_top
    import sap_pkg::*;
#(
    parameter int W       = 24,
    parameter int SLOTS   = 32,
    parameter int LANES   = 3,
    parameter int SHORT_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 fclk,
    input  logic [1:0]           dac_fmt,
    input  logic                 adc_i2s,
    input  logic                 aux_sel,
    input  logic [1:0]           loop_reg,
    input  logic [1:0]           loop_pin,
    input  logic                 par_ctl,
    input  logic [LANES-1:0]     dac_sd,
    input  logic                 aux_sd,
    input  logic [W-1:0]         adc_left,
    input  logic [W-1:0]         adc_right,
    output logic                 adc_sd,
    output logic [LANES*2*W-1:0] dac_words,
    output logic                 dac_valid
);
    localparam int POSW = $clog2(SLOTS) + 1;

    logic            rise, fall, lr, half_start, aux_q;
    logic [POSW-1:0] pos, next_pos;
    logic [LANES-1:0] sd_q, lane_bit;
    logic [1:0]      loop_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q  <= '0;
            aux_q <= 1'b0;
        end else begin
            sd_q  <= dac_sd;
            aux_q <= aux_sd;
        end
    end

    assign loop_eff = par_ctl ? (loop_reg | loop_pin) : loop_reg;

    for (genvar g = 0; g < LANES; g++) begin : g_route
        if (g == 0) begin : g_low
            assign lane_bit[g] = (loop_eff == LOOP_LOW) ? adc_sd : sd_q[g];
        end else begin : g_high
            assign lane_bit[g] = (loop_eff == LOOP_HIGH) ? adc_sd : sd_q[g];
        end
    end

    sap_edge #(.SLOTS(SLOTS), .POSW(POSW)) u_edge (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk),
        .rise(rise), .fall(fall), .lr(lr), .half_start(half_start),
        .pos(pos), .next_pos(next_pos)
    );

    sap_rx #(.W(W), .SLOTS(SLOTS), .LANES(LANES), .SHORT_W(SHORT_W), .POSW(POSW)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .half_start(half_start),
        .pos(pos), .lr(lr), .fmt(dac_fmt), .lane_bit(lane_bit),
        .words(dac_words), .valid(dac_valid)
    );

    sap_tx #(.W(W), .SLOTS(SLOTS), .POSW(POSW)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall(fall), .lr(lr), .next_pos(next_pos),
        .i2s(adc_i2s), .aux_sel(aux_sel), .aux_bit(aux_q),
        .word_l(adc_left), .word_r(adc_right), .sd(adc_sd)
    );
endmodule

// File: tb/sap_top_test.sv
`timescale 1ns/1ps
module sap_top_test;
    localparam int W = 24, SLOTS = 32, LANES = 3, NF = 3, WW = LANES*2*W;

    logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fclk = 1'b0;
    logic [1:0] dac_fmt = 2'd0, loop_reg = 2'd0, loop_pin = 2'd0;
    logic adc_i2s = 1'b0, aux_sel = 1'b0, par_ctl = 1'b0, aux_sd = 1'b0;
    logic [LANES-1:0] dac_sd = '0;
    logic [W-1:0] adc_left = '0, adc_right = '0;
    logic adc_sd, dac_valid;
    logic [WW-1:0] dac_words;

    int errs = 0, checks = 0, vcount = 0;
    logic [WW-1:0] cap [0:63];
    logic [W-1:0] wl [0:NF][0:LANES-1];
    logic [W-1:0] wr [0:NF][0:LANES-1];
    logic [W-1:0] al [0:NF];
    logic [W-1:0] ar [0:NF];

    always #2.5 clk = ~clk;

    sap_top uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk), .dac_fmt(dac_fmt),
        .adc_i2s(adc_i2s), .aux_sel(aux_sel), .loop_reg(loop_reg), .loop_pin(loop_pin),
        .par_ctl(par_ctl), .dac_sd(dac_sd), .aux_sd(aux_sd), .adc_left(adc_left),
        .adc_right(adc_right), .adc_sd(adc_sd), .dac_words(dac_words), .dac_valid(dac_valid)
    );

    always @(negedge clk) begin
        if (rst_n && dac_valid) begin
            if (vcount < 64) cap[vcount] = dac_words;
            vcount = vcount + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mix(input int a, input int b, input int c);
        logic [31:0] x;
        x = 32'(a) * 32'h9E3779B1 + 32'(b) * 32'h85EBCA6B + 32'(c) * 32'hC2B2AE35 + 32'h1234567;
        x = x ^ (x >> 13);
        return x[W-1:0];
    endfunction

    function automatic logic dbit(input logic [1:0] f, input logic [W-1:0] w, input int p, input int l);
        logic junk;
        junk = ((p + l) % 2) == 1;
        case (f)
            2'd0: return (p < 24) ? w[23-p] : junk;
            2'd1: return (p >= 12) ? w[31-p] : junk;
            2'd2: return (p >= 8) ? w[31-p] : junk;
            default: return (p >= 1 && p <= 24) ? w[24-p] : junk;
        endcase
    endfunction

    function automatic logic abit(input logic i2s, input logic [W-1:0] w, input int p);
        if (i2s) return (p >= 1 && p <= 24) ? w[24-p] : 1'b0;
        return (p < 24) ? w[23-p] : 1'b0;
    endfunction

    function automatic logic auxp(input int f, input bit left, input int p);
        return ((f * 7 + (left ? 3 : 0) + p * 5) % 3) == 0;
    endfunction

    task automatic drive_bit(input logic lr, input logic [LANES-1:0] d, input logic ax,
                             output logic s_lo, output logic s_hi);
        @(negedge clk);
        bclk = 1'b0; fclk = lr; dac_sd = d; aux_sd = ax;
        repeat (4) @(negedge clk);
        s_lo = adc_sd;
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        s_hi = adc_sd;
    endtask

    task automatic send_half(input int f, input bit left,
                             output logic [SLOTS-1:0] lo, output logic [SLOTS-1:0] hi);
        logic lr, x, y;
        logic [LANES-1:0] d;
        lr = (dac_fmt == 2'd3) ? !left : left;
        for (int p = 0; p < SLOTS; p++) begin
            for (int l = 0; l < LANES; l++) d[l] = dbit(dac_fmt, left ? wl[f][l] : wr[f][l], p, l);
            drive_bit(lr, d, auxp(f, left, p), x, y);
            lo[p] = x;
            hi[p] = y;
        end
    endtask

    task automatic run_test(input string tagw, input string tagt, input logic [1:0] fmt,
                            input bit aux, input logic [1:0] lreg, input logic [1:0] lpin,
                            input bit par, input int seed, input bit first);
        logic [SLOTS-1:0] lo, hi, ex;
        logic [WW-1:0] exp;
        logic [1:0] le;
        int base;
        rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0;
        dac_fmt = fmt; adc_i2s = (fmt == 2'd3); aux_sel = aux;
        loop_reg = lreg; loop_pin = lpin; par_ctl = par;
        for (int f = 0; f <= NF; f++) begin
            for (int l = 0; l < LANES; l++) begin
                wl[f][l] = mix(seed, f, l);
                wr[f][l] = mix(seed, f, l + 8);
            end
            al[f] = mix(seed, f, 20);
            ar[f] = mix(seed, f, 21);
        end
        if (seed == 0) begin
            wl[0][0] = 24'hFFFFFF; wr[0][0] = 24'h800001;
            al[0] = 24'h800000;    ar[0] = 24'h000001;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        if (first) begin
            chk(dac_words == '0, "R1", "reset words", dac_words, '0);
            chk(dac_valid == 1'b0, "R1", "reset strobe", WW'(dac_valid), '0);
            chk(adc_sd == 1'b0, "R1", "reset line", WW'(adc_sd), '0);
        end
        base = vcount;
        send_half(NF, 1'b0, lo, hi);
        for (int f = 0; f < NF; f++) begin
            adc_left = al[f]; adc_right = ar[f];
            for (int s = 0; s < 2; s++) begin
                send_half(f, s == 0, lo, hi);
                for (int p = 0; p < SLOTS; p++)
                    ex[p] = aux ? auxp(f, s == 0, p) : abit(adc_i2s, s == 0 ? al[f] : ar[f], p);
                chk(lo == ex, tagt, "serial half", WW'(lo), WW'(ex));
                chk(lo == hi, "R8", "line moved at rising edge", WW'(hi), WW'(lo));
            end
        end
        adc_left = al[NF]; adc_right = ar[NF];
        send_half(NF, 1'b1, lo, hi);
        repeat (4) @(negedge clk);
        chk(vcount - base == NF, "R6", "strobe count", WW'(vcount - base), WW'(NF));
        le = par ? (lreg | lpin) : lreg;
        for (int f = 0; f < NF; f++) begin
            for (int l = 0; l < LANES; l++) begin
                if ((l == 0 && le == 2'd1) || (l > 0 && le == 2'd2)) begin
                    exp[(2*l)*W +: W]   = al[f];
                    exp[(2*l+1)*W +: W] = ar[f];
                end else begin
                    exp[(2*l)*W +: W]   = (fmt == 2'd1) ? {wl[f][l][19:0], 4'b0} : wl[f][l];
                    exp[(2*l+1)*W +: W] = (fmt == 2'd1) ? {wr[f][l][19:0], 4'b0} : wr[f][l];
                end
            end
            chk(cap[base+f] == exp, tagw, "frame words", cap[base+f], exp);
        end
    endtask

    initial begin
        run_test("R2", "R7", 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 0, 1'b1);
        run_test("R5", "R7", 2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1, 1'b0);
        run_test("R4", "R7", 2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 2, 1'b0);
        run_test("R3", "R7", 2'd3, 1'b0, 2'd0, 2'd0, 1'b0, 3, 1'b0);
        run_test("R2", "R9", 2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 4, 1'b0);
        run_test("R3", "R9", 2'd3, 1'b1, 2'd0, 2'd0, 1'b0, 5, 1'b0);
        run_test("R10", "R7", 2'd0, 1'b0, 2'd1, 2'd0, 1'b0, 6, 1'b0);
        run_test("R11", "R7", 2'd3, 1'b0, 2'd2, 2'd0, 1'b0, 7, 1'b0);
        run_test("R12", "R7", 2'd0, 1'b0, 2'd0, 2'd1, 1'b1, 8, 1'b0);
        run_test("R12", "R7", 2'd0, 1'b0, 2'd0, 2'd2, 1'b0, 9, 1'b0);
        run_test("R12", "R7", 2'd3, 1'b0, 2'd3, 2'd0, 1'b0, 10, 1'b0);
        run_test("R12", "R7", 2'd0, 1'b0, 2'd2, 2'd1, 1'b1, 11, 1'b0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule